// File: doc/BRIEF.md
# Video Genlock VSYNC Aligner

This block makes a display timing generator follow the frame timing of an incoming captured video stream. It watches two vertical sync inputs on one 27 MHz clock. One comes from the capture path and one from the display controller. Each input passes through a synchronizer, and the block then picks out the edge that software selected for it. After a selected capture edge and a programmed number of clocks, the block raises a one-clock lock pulse. The display timing generator uses that pulse to restart its frame.

Lock works in one of two modes. In one-shot mode the block arms once, fires once and then disarms itself. In continuous mode it realigns on every capture frame. If both modes are enabled, one-shot takes precedence. Two per-field watchdog counters detect a capture stream that has gone silent. A field-parity input selects which counter runs. Each counter reloads on every capture sync edge. A sticky flag sets when a counter runs down to zero. After a lock pulse, a status bit records when the selected display sync edge arrives, which confirms that the display side responded.

Software reaches the block through a four-word register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `vsync_genlock`

## Requirements
- R1: After reset, all four registers read zero and no lock pulse is produced. The registers are: word 0 control, word 1 delay, word 2 watchdog reload, word 3 status.
- R2: In control word 0, bit 2 = 0 selects the rising edge of the capture sync. The lock pulse is high for exactly one cycle. It is high in the cycle after the (D+3)-th rising clock edge, counting as the first edge the one that samples the new capture level. D is word 1 bits [20:0]. The other capture edge produces no pulse.
- R3: Control bit 2 = 1 selects the falling capture edge, with the same D+3 timing. A rising edge then produces no pulse.
- R4: A selected capture edge that arrives while a delay count is running restarts the count. The pulse then falls D+3 edges after the later sync edge, and no pulse comes from the earlier one.
- R5: With control bit 1 (continuous) set, every selected capture edge produces a lock pulse.
- R6: Control bit 0 (one-shot) produces exactly one pulse, and the block then clears bit 0 itself. A later capture edge produces no pulse until software sets the bit again.
- R7: When bits 0 and 1 are both set, the first pulse follows one-shot behaviour. After that pulse, control reads with bit 0 clear and bit 1 still set, and continuous pulses follow.
- R8: When control bits 0 and 1 are both clear, no lock pulse is produced.
- R9: Word 2 holds the odd-field reload in bits [15:0] and the even-field reload in bits [31:16]. With control bit 4 (watchdog on) set and the field input high, a capture edge loads the odd counter with reload N. Status bit 0 then sets after the (N+3)-th edge counted as in R2.
- R10: With the field input low, the even counter runs and status bit 1 sets after N+3 edges, using the even reload. The odd counter is frozen, and status bit 0 stays clear.
- R11: With control bit 4 clear, neither watchdog flag sets.
- R12: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R13: After a lock pulse, status bit 2 sets on the next display sync edge of the kind selected by control bit 3 (0 rising, 1 falling). The other edge does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_vsync | input | 1 | Vertical sync from the capture path, asynchronous |
| disp_vsync | input | 1 | Vertical sync from the display controller, asynchronous |
| field_odd | input | 1 | Current capture field parity, 1 = odd |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lock_pulse | output | 1 | One-clock frame realignment pulse |

## Verification
A sync input change reaches the edge detector two edges later. The result then takes one more edge to register, so the lock pulse is due after D+3 edges and a watchdog flag after N+3 edges. The display-seen status bit is due three edges after the display sync changes. Each timed check drives an input at a falling clock edge and then counts rising edges. It samples the outputs at every following falling edge and compares the index of the first pulse or flag against these counts. Checks for absence of a pulse or flag watch the whole window in which one could appear.

// File: rtl/vgl_pkg.sv
package vgl_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_DELAY = 2'd1;
  localparam logic [ADDR_W-1:0] A_RLD   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd3;

  localparam int unsigned ST_ODD   = 0;
  localparam int unsigned ST_EVEN  = 1;
  localparam int unsigned ST_ALIGN = 2;
  localparam int unsigned ST_W     = 3;

  typedef struct packed {
    logic wd_on;      // bit 4
    logic disp_fall;  // bit 3
    logic cap_fall;   // bit 2
    logic cont;       // bit 1
    logic oneshot;    // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vgl_sync_edge.sv
module vgl_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] pipe_q, pipe_d;
  logic              last_q, last_d;

  generate
    if (STAGES == 1) begin : g_one
      assign pipe_d = async_in;
    end else begin : g_many
      assign pipe_d = {pipe_q[STAGES-2:0], async_in};
    end
  endgenerate

  assign last_d = pipe_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    if (fall_sel) edge_o = last_q & ~pipe_q[STAGES-1];
    else          edge_o = ~last_q & pipe_q[STAGES-1];
  end
endmodule

// File: rtl/vgl_lock_timer.sv
module vgl_lock_timer #(
  parameter int unsigned DW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  input  logic [DW-1:0] delay,
  output logic          pulse
);
  logic          run_q, run_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (!arm) begin
      run_d = 1'b0;
    end else if (trig) begin
      run_d = 1'b1;
      cnt_d = delay;
    end else if (run_q) begin
      if (cnt_zero) run_d = 1'b0;
      else          cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse = run_q & cnt_zero;
endmodule

// File: rtl/vgl_field_wdog.sv
module vgl_field_wdog #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] reload,
  input  logic          reload_now,
  input  logic          count_en,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          live;

  assign live = count_en & ~reload_now & (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (reload_now) cnt_d = reload;
    else if (live)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = live & (cnt_q == {{(TW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/vgl_regs.sv
module vgl_regs
  import vgl_pkg::*;
#(
  parameter int unsigned DW = 21,
  parameter int unsigned TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 lock_pulse,
  input  logic                 disp_edge,
  input  logic [1:0]           expire,
  output ctrl_t                ctrl,
  output logic [DW-1:0]        delay,
  output logic [TW-1:0]        rld_odd,
  output logic [TW-1:0]        rld_even,
  output logic [ST_W-1:0]      flags,
  output logic [ST_W-1:0]      clr,
  output logic [REG_W-1:0]     rdata
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [DW-1:0]    dly_q, dly_d;
  logic [TW-1:0]    odd_q, odd_d, even_q, even_d;
  logic [ST_W-1:0]  flg_q, flg_d, set_v;
  logic             wait_q, wait_d;

  always_comb begin
    ctrl_d = ctrl_q;
    dly_d  = dly_q;
    odd_d  = odd_q;
    even_d = even_q;
    clr    = '0;
    if (we) begin
      case (addr)
        A_CTRL:  ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        A_DELAY: dly_d  = wdata[DW-1:0];
        A_RLD: begin
          odd_d  = wdata[TW-1:0];
          even_d = wdata[2*TW-1:TW];
        end
        default: clr = wdata[ST_W-1:0];
      endcase
    end else if (lock_pulse && ctrl_q.oneshot) begin
      ctrl_d.oneshot = 1'b0;
    end
    wait_d = wait_q;
    if (lock_pulse)     wait_d = 1'b1;
    else if (disp_edge) wait_d = 1'b0;
    set_v = '0;
    set_v[ST_ODD]   = expire[0];
    set_v[ST_EVEN]  = expire[1];
    set_v[ST_ALIGN] = wait_q & disp_edge;
    flg_d = (flg_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dly_q  <= '0;
      odd_q  <= '0;
      even_q <= '0;
      flg_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      dly_q  <= dly_d;
      odd_q  <= odd_d;
      even_q <= even_d;
      flg_q  <= flg_d;
      wait_q <= wait_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_DELAY: rdata[DW-1:0]     = dly_q;
      A_RLD: begin
        rdata[TW-1:0]    = odd_q;
        rdata[2*TW-1:TW] = even_q;
      end
      default: rdata[ST_W-1:0] = flg_q;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign delay    = dly_q;
  assign rld_odd  = odd_q;
  assign rld_even = even_q;
  assign flags    = flg_q;
endmodule

// File: rtl/vsync_genlock.sv
module vsync_genlock
  import vgl_pkg::*;
#(
  parameter int unsigned DELAY_W     = 21,
  parameter int unsigned TOUT_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_vsync,
  input  logic        disp_vsync,
  input  logic        field_odd,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        lock_pulse
);
  localparam int unsigned NFIELD = 2;

  logic [1:0]         rst_pipe;
  logic               rst_n_i;
  logic               cap_edge, disp_edge;
  ctrl_t              ctrl;
  logic [DELAY_W-1:0] delay;
  logic [TOUT_W-1:0]  rld [NFIELD];
  logic [NFIELD-1:0]  expire;
  logic [ST_W-1:0]    flags, clr;
  logic               arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  vgl_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n_i), .async_in(cap_vsync),
    .fall_sel(ctrl.cap_fall), .edge_o(cap_edge)
  );

  vgl_sync_edge #(.STAGES(SYNC_STAGES)) u_disp_sync (
    .clk(clk), .rst_n(rst_n_i), .async_in(disp_vsync),
    .fall_sel(ctrl.disp_fall), .edge_o(disp_edge)
  );

  assign arm = ctrl.oneshot | ctrl.cont;

  vgl_lock_timer #(.DW(DELAY_W)) u_timer (
    .clk(clk), .rst_n(rst_n_i), .arm(arm), .trig(cap_edge),
    .delay(delay), .pulse(lock_pulse)
  );

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_wd
      logic run_this;
      assign run_this = ctrl.wd_on & ((g == 0) ? field_odd : ~field_odd);
      vgl_field_wdog #(.TW(TOUT_W)) u_wd (
        .clk(clk), .rst_n(rst_n_i), .reload(rld[g]),
        .reload_now(cap_edge), .count_en(run_this), .expire(expire[g])
      );
    end
  endgenerate

  vgl_regs #(.DW(DELAY_W), .TW(TOUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .lock_pulse(lock_pulse), .disp_edge(disp_edge),
    .expire(expire), .ctrl(ctrl), .delay(delay), .rld_odd(rld[0]),
    .rld_even(rld[1]), .flags(flags), .clr(clr), .rdata(reg_rdata)
  );
endmodule

// File: rtl/vgl_checker.sv
module vgl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_pulse,
  input logic       oneshot,
  input logic       cont,
  input logic       wd_on,
  input logic       reg_we,
  input logic [2:0] flags,
  input logic [2:0] clr
);
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> !lock_pulse);

  p_oneshot_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_pulse && oneshot && !reg_we) |=> !oneshot);

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oneshot && !cont && $past(!oneshot && !cont)) |-> !lock_pulse);

  p_odd_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr[0]) |=> flags[0]);

  p_even_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clr[1]) |=> flags[1]);

  p_odd_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(wd_on));

  p_even_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(wd_on));
endmodule

bind vsync_genlock vgl_checker u_chk (
  .clk(clk), .rst_n(rst_n_i), .lock_pulse(lock_pulse),
  .oneshot(ctrl.oneshot), .cont(ctrl.cont), .wd_on(ctrl.wd_on),
  .reg_we(reg_we), .flags(flags), .clr(clr)
);

// File: tb/vsync_genlock_test.sv
`timescale 1ns/1ps
module vsync_genlock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_vsync = 1'b0;
  logic        disp_vsync = 1'b0;
  logic        field_odd = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lock_pulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsync_genlock uut (
    .clk(clk), .rst_n(rst_n), .cap_vsync(cap_vsync), .disp_vsync(disp_vsync),
    .field_odd(field_odd), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_pulse(lock_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cap(input logic v);
    @(negedge clk);
    cap_vsync = v;
  endtask

  // counts posedges, samples at each negedge; first pulse index and number of pulses
  task automatic watch_pulse(input int maxc, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int k = 1; k <= maxc; k++) begin
      @(posedge clk); @(negedge clk);
      if (lock_pulse) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic watch_flag(input int bitn, input int maxc, output int first);
    first = -1;
    reg_addr = 2'd3;
    for (int k = 1; k <= maxc; k++) begin
      @(posedge clk); @(negedge clk);
      if (reg_rdata[bitn] && first < 0) first = k;
    end
  endtask

  task automatic quiesce();
    wr(2'd0, 32'h0);
    set_cap(1'b0);
    disp_vsync = 1'b0;
    idle(6);
    wr(2'd3, 32'h7);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d == 0, "R1 register zero", int'(d), 0);
    end
    check(lock_pulse == 1'b0, "R1 no pulse", int'(lock_pulse), 0);
  endtask

  task automatic t_rise(input int dl);
    int f, n;
    quiesce();
    wr(2'd1, dl);
    wr(2'd0, 32'h2);
    set_cap(1'b1);
    watch_pulse(dl + 8, f, n);
    check(f == dl + 3, "R2 rising delay timing", f, dl + 3);
    check(n == 1, "R2 one pulse", n, 1);
    set_cap(1'b0);
    watch_pulse(dl + 8, f, n);
    check(n == 0, "R2 other edge ignored", n, 0);
    set_cap(1'b1);
    watch_pulse(dl + 8, f, n);
    check(f == dl + 3 && n == 1, "R5 continuous repeats", f, dl + 3);
  endtask

  task automatic t_fall();
    int f, n;
    quiesce();
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h6);
    set_cap(1'b1);
    watch_pulse(12, f, n);
    check(n == 0, "R3 rising ignored", n, 0);
    set_cap(1'b0);
    watch_pulse(12, f, n);
    check(f == 7 && n == 1, "R3 falling timing", f, 7);
  endtask

  task automatic t_restart();
    int f, n, tot;
    quiesce();
    wr(2'd1, 32'd12);
    wr(2'd0, 32'h2);
    set_cap(1'b1);
    watch_pulse(5, f, n);
    tot = n;
    set_cap(1'b0);
    watch_pulse(2, f, n);
    tot += n;
    check(tot == 0, "R4 no early pulse", tot, 0);
    set_cap(1'b1);
    watch_pulse(20, f, n);
    check(f == 15 && n == 1, "R4 restarted count", f, 15);
  endtask

  task automatic t_oneshot();
    int f, n;
    logic [31:0] d;
    quiesce();
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h1);
    set_cap(1'b1);
    watch_pulse(8, f, n);
    check(f == 5 && n == 1, "R6 single pulse", f, 5);
    rd(2'd0, d);
    check(d[0] == 1'b0, "R6 self clear", int'(d[0]), 0);
    set_cap(1'b0);
    idle(4);
    set_cap(1'b1);
    watch_pulse(12, f, n);
    check(n == 0, "R6 disarmed", n, 0);
  endtask

  task automatic t_both();
    int f, n;
    logic [31:0] d;
    quiesce();
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h3);
    set_cap(1'b1);
    watch_pulse(8, f, n);
    check(f == 4 && n == 1, "R7 first pulse", f, 4);
    rd(2'd0, d);
    check(d[1:0] == 2'b10, "R7 oneshot cleared, continuous kept", int'(d[1:0]), 2);
    set_cap(1'b0);
    idle(4);
    set_cap(1'b1);
    watch_pulse(8, f, n);
    check(f == 4 && n == 1, "R7 continuous after", f, 4);
  endtask

  task automatic t_off();
    int f, n;
    quiesce();
    wr(2'd1, 32'd0);
    set_cap(1'b1);
    watch_pulse(30, f, n);
    check(n == 0, "R8 disabled no pulse", n, 0);
  endtask

  task automatic t_align();
    int f, n;
    logic [31:0] d;
    quiesce();
    wr(2'd1, 32'd0);
    wr(2'd0, 32'hA);
    set_cap(1'b1);
    watch_pulse(6, f, n);
    check(n == 1, "R13 pulse present", n, 1);
    @(negedge clk); disp_vsync = 1'b1;
    idle(6);
    rd(2'd3, d);
    check(d[2] == 1'b0, "R13 unselected display edge", int'(d[2]), 0);
    @(negedge clk); disp_vsync = 1'b0;
    idle(6);
    rd(2'd3, d);
    check(d[2] == 1'b1, "R13 selected display edge", int'(d[2]), 1);
    wr(2'd3, 32'h0);
    rd(2'd3, d);
    check(d[2] == 1'b1, "R12 write zero keeps", int'(d[2]), 1);
    wr(2'd3, 32'h4);
    rd(2'd3, d);
    check(d[2] == 1'b0, "R12 write one clears", int'(d[2]), 0);
  endtask

  task automatic t_wd_odd();
    int f;
    logic [31:0] d;
    quiesce();
    field_odd = 1'b1;
    wr(2'd2, {16'd50, 16'd20});
    wr(2'd0, 32'h10);
    set_cap(1'b1);
    watch_flag(0, 30, f);
    check(f == 23, "R9 odd timeout timing", f, 23);
    rd(2'd3, d);
    check(d[1] == 1'b0, "R10 even idle in odd field", int'(d[1]), 0);
    wr(2'd3, 32'h1);
    rd(2'd3, d);
    check(d[0] == 1'b0, "R12 odd flag cleared", int'(d[0]), 0);
  endtask

  task automatic t_wd_even();
    int f;
    logic [31:0] d;
    quiesce();
    field_odd = 1'b0;
    wr(2'd2, {16'd9, 16'd5});
    wr(2'd0, 32'h10);
    set_cap(1'b1);
    watch_flag(1, 20, f);
    check(f == 12, "R10 even timeout timing", f, 12);
    rd(2'd3, d);
    check(d[0] == 1'b0, "R10 odd frozen", int'(d[0]), 0);
  endtask

  task automatic t_wd_off();
    logic [31:0] d;
    quiesce();
    field_odd = 1'b1;
    wr(2'd2, {16'd3, 16'd3});
    set_cap(1'b1);
    idle(20);
    rd(2'd3, d);
    check(d[1:0] == 2'b00, "R11 watchdog off", int'(d[1:0]), 0);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_rise(0);
    t_rise(7);
    t_fall();
    t_restart();
    t_oneshot();
    t_both();
    t_off();
    t_align();
    t_wd_odd();
    t_wd_even();
    t_wd_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule